// File: doc/BRIEF.md
# Configuration Sequencer for a Programmable Device

This block steps a programmable device from the moment its supply is good up to the point where user logic runs. It counts out a settling delay after power-good, keeps the shared open-drain INIT line pulled low while the configuration memory is wiped, then lets go of the line. It waits until every device on that line has also let go before it latches the mode pins and begins accepting configuration frames. A clean final frame leads through a short start-up phase into operation, where DONE is up, user I/Os are enabled and the internal reset is removed.

Several things send the block back to initialization. A bit error on a frame being written does it, and so does a low on the reset or program request before operation, or the INIT line falling during frame loading. Once the block is running, only the program request brings it back. A strap input can let any reconfiguration after the first completed one skip the memory wipe. The reset request, the program request and the INIT line are brought in through two-flop synchronizers. The power-good input and the frame handshake are taken as already synchronous.

Top module: `cfg_seq`

## Requirements
- R1: After reset, or while power-good is low, INIT is driven low, HDC is high, and LDC, DONE, the memory clear, DOUT enable, I/O activation and internal reset release are all low. As a vector {init_drive, done, hdc, ldc, mem_clear, dout_en, io_active, int_rst_rel} this is 8'hA0.
- R2: With power-good raised and both requests high, the memory clear first reads high POR_CYCLES+1 clocks after the first rising edge that sees power-good.
- R3: The memory clear stays high for exactly CLR_CYCLES consecutive clocks, with INIT driven low on each of them. On the next clock INIT is released and the output vector is 8'h20.
- R4: Frame loading starts, shown by DOUT enable, only after the synchronized INIT line has read high on two consecutive clocks. That is 4 clocks after the pin goes high. A one-clock high pulse never starts it.
- R5: The configuration mode output takes the value of the mode pins at the clock that enters frame loading, and holds it while the pins change afterwards.
- R6: During frame loading the output vector is 8'h24: INIT released, HDC high, LDC low, DOUT enabled, DONE low.
- R7: A frame strobe carrying the last-frame flag, with no bit error, leads to one clock of start-up (vector 8'h60, DONE high). Operation follows on the next clock (vector 8'h53: DONE, I/O active, reset released, HDC low, LDC high).
- R8: A bit error with the frame strobe returns the block to initialization (vector 8'hA0 on the next clock), even when the last-frame flag is set on the same clock. A bit error without the frame strobe is ignored.
- R9: Before operation, a low on the synchronized reset or program request returns the block to initialization and holds it there (INIT driven low) until both are high. A low on the INIT line during frame loading also returns it to initialization.
- R10: In operation, the reset request and the INIT line have no effect. A low on the program request returns the block to initialization 3 clocks after the pin falls.
- R11: With keep-memory high and at least one completed configuration since power-up, a return to initialization skips the memory clear. In every other case the clear runs.
- R12: Power-good falling forces the power-on state on the next clock. It also forgets any completed configuration, so the next pass runs the full delay and the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply settled indication, synchronous |
| init_line_i | input | 1 | Level read back from the shared INIT line |
| reset_req_ni | input | 1 | Reset request, active low, asynchronous |
| prgm_req_ni | input | 1 | Program request, active low, asynchronous |
| mode_i | input | MODE_W | Mode select pins |
| frame_valid_i | input | 1 | A configuration frame is written this clock |
| frame_last_i | input | 1 | The written frame is the final one |
| bit_err_i | input | 1 | Error detected on the written frame |
| keep_mem_i | input | 1 | Skip the memory clear on reconfiguration |
| init_drive_o | output | 1 | Pull the INIT line low |
| done_o | output | 1 | DONE |
| hdc_o | output | 1 | High during configuration |
| ldc_o | output | 1 | Low during configuration |
| mem_clear_o | output | 1 | Configuration memory clear strobe |
| dout_en_o | output | 1 | DOUT enable |
| io_active_o | output | 1 | User I/O activation |
| int_rst_rel_o | output | 1 | Internal reset release |
| cfg_mode_o | output | MODE_W | Mode latched at entry to frame loading |

## Verification
The collision that matters is a bit error arriving on the same frame strobe as the last-frame flag, where completion and abort compete within one clock. The bench drives all three inputs together, both in a directed case and in random frame runs where the error can land on the final frame. It expects the initialization vector on the next clock and no DONE pulse. Randomly placed gap clocks, which carry a bit error or a last-frame flag without the strobe, must leave frame loading undisturbed.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_HOLD   = 3'd1,
    ST_CLEAR  = 3'd2,
    ST_WAIT   = 3'd3,
    ST_CONFIG = 3'd4,
    ST_START  = 3'd5,
    ST_OPER   = 3'd6
  } cfg_state_e;

  typedef struct packed {
    logic init_drive;
    logic done;
    logic hdc;
    logic ldc;
    logic mem_clear;
    logic dout_en;
    logic io_active;
    logic rst_rel;
  } cfg_outs_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // R2/R3: window counter never passes its terminal value
  p_timer_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_timer_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);

endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              init_s_i,
  input  logic              reset_s_i,
  input  logic              prgm_s_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              frame_valid_i,
  input  logic              frame_last_i,
  input  logic              bit_err_i,
  input  logic              keep_mem_i,
  input  logic              por_exp_i,
  input  logic              clr_exp_i,
  output cfg_state_e        state_o,
  output logic [MODE_W-1:0] mode_o
);

  cfg_state_e        state_q, state_d;
  logic              init_hi_q;
  logic              cfg_once_q;
  logic [MODE_W-1:0] mode_q;
  logic              req_ok;
  logic              skip_clr;
  logic              frame_err;
  logic              frame_end;

  assign req_ok    = reset_s_i && prgm_s_i;
  assign skip_clr  = keep_mem_i && cfg_once_q;
  assign frame_err = frame_valid_i && bit_err_i;
  assign frame_end = frame_valid_i && frame_last_i;

  always_comb begin
    state_d = state_q;
    if (!pwr_good_i) begin
      state_d = ST_POR;
    end else begin
      unique case (state_q)
        ST_POR:    if (por_exp_i) state_d = ST_HOLD;
        ST_HOLD:   if (req_ok) state_d = skip_clr ? ST_WAIT : ST_CLEAR;
        ST_CLEAR: begin
          if (!req_ok)        state_d = ST_HOLD;
          else if (clr_exp_i) state_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (!req_ok)                    state_d = ST_HOLD;
          else if (init_s_i && init_hi_q) state_d = ST_CONFIG;
        end
        ST_CONFIG: begin
          // abort outranks completion when both land on one strobe
          if (!req_ok || !init_s_i || frame_err) state_d = ST_HOLD;
          else if (frame_end)                    state_d = ST_START;
        end
        ST_START:  state_d = req_ok ? ST_OPER : ST_HOLD;
        ST_OPER:   if (!prgm_s_i) state_d = ST_HOLD;
        default:   state_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_POR;
      init_hi_q  <= 1'b0;
      cfg_once_q <= 1'b0;
      mode_q     <= '0;
    end else begin
      state_q   <= state_d;
      init_hi_q <= (state_q == ST_WAIT) && init_s_i;
      if (!pwr_good_i)              cfg_once_q <= 1'b0;
      else if (state_q == ST_OPER)  cfg_once_q <= 1'b1;
      if (state_q == ST_WAIT && state_d == ST_CONFIG) mode_q <= mode_i;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;

  p_cfg_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_CONFIG) |-> $past(init_s_i) && $past(init_s_i, 2));

  p_mode_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIG) && $past(state_q == ST_CONFIG) |-> $stable(mode_q));

  p_err_blocks_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIG) && frame_err |=> state_q != ST_START);

  p_cfg_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIG) && pwr_good_i && !init_s_i |=> state_q == ST_HOLD);

  p_oper_keeps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPER) && prgm_s_i && pwr_good_i |=> state_q == ST_OPER);

  p_skip_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) && keep_mem_i && cfg_once_q && pwr_good_i |=> state_q != ST_CLEAR);

  p_pwr_loss_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> state_q == ST_POR && !cfg_once_q);

endmodule

// File: rtl/cfg_out_dec.sv
module cfg_out_dec
  import cfg_seq_pkg::*;
(
  input  cfg_state_e state_i,
  output cfg_outs_t  outs_o
);

  always_comb begin
    outs_o            = '0;
    outs_o.hdc        = 1'b1;
    unique case (state_i)
      ST_POR, ST_HOLD: outs_o.init_drive = 1'b1;
      ST_CLEAR: begin
        outs_o.init_drive = 1'b1;
        outs_o.mem_clear  = 1'b1;
      end
      ST_WAIT:   ;
      ST_CONFIG: outs_o.dout_en = 1'b1;
      ST_START:  outs_o.done    = 1'b1;
      ST_OPER: begin
        outs_o.done      = 1'b1;
        outs_o.io_active = 1'b1;
        outs_o.rst_rel   = 1'b1;
        outs_o.hdc       = 1'b0;
        outs_o.ldc       = 1'b1;
      end
      default:   outs_o.init_drive = 1'b1;
    endcase
  end

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int POR_CYCLES  = 40,
  parameter int CLR_CYCLES  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              init_line_i,
  input  logic              reset_req_ni,
  input  logic              prgm_req_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              frame_valid_i,
  input  logic              frame_last_i,
  input  logic              bit_err_i,
  input  logic              keep_mem_i,
  output logic              init_drive_o,
  output logic              done_o,
  output logic              hdc_o,
  output logic              ldc_o,
  output logic              mem_clear_o,
  output logic              dout_en_o,
  output logic              io_active_o,
  output logic              int_rst_rel_o,
  output logic [MODE_W-1:0] cfg_mode_o
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] sync_d, sync_q;
  logic             init_s, prgm_s, reset_s;
  logic             por_exp, clr_exp;
  cfg_state_e       state;
  cfg_outs_t        outs;

  assign sync_d = {init_line_i, prgm_req_ni, reset_req_ni};
  assign {init_s, prgm_s, reset_s} = sync_q;

  cfg_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NSYNC{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  cfg_timer #(.LIMIT(POR_CYCLES)) u_por_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (pwr_good_i && state == ST_POR),
    .expired_o(por_exp)
  );

  cfg_timer #(.LIMIT(CLR_CYCLES)) u_clr_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state == ST_CLEAR),
    .expired_o(clr_exp)
  );

  cfg_fsm #(.MODE_W(MODE_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_good_i   (pwr_good_i),
    .init_s_i     (init_s),
    .reset_s_i    (reset_s),
    .prgm_s_i     (prgm_s),
    .mode_i       (mode_i),
    .frame_valid_i(frame_valid_i),
    .frame_last_i (frame_last_i),
    .bit_err_i    (bit_err_i),
    .keep_mem_i   (keep_mem_i),
    .por_exp_i    (por_exp),
    .clr_exp_i    (clr_exp),
    .state_o      (state),
    .mode_o       (cfg_mode_o)
  );

  cfg_out_dec u_dec (
    .state_i(state),
    .outs_o (outs)
  );

  assign init_drive_o  = outs.init_drive;
  assign done_o        = outs.done;
  assign hdc_o         = outs.hdc;
  assign ldc_o         = outs.ldc;
  assign mem_clear_o   = outs.mem_clear;
  assign dout_en_o     = outs.dout_en;
  assign io_active_o   = outs.io_active;
  assign int_rst_rel_o = outs.rst_rel;

  p_clear_holds_init_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_clear_o |-> init_drive_o);

  p_release_after_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_clear_o) && pwr_good_i && $past(reset_s && prgm_s) |-> !init_drive_o);

  p_dout_config_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> !init_drive_o && hdc_o && !ldc_o && !done_o);

  p_io_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_active_o) |-> $past(done_o) && int_rst_rel_o);

  p_unpowered_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> init_drive_o && !done_o && !io_active_o && !int_rst_rel_o);

endmodule

// File: tb/cfg_seq_test.sv
module cfg_seq_test;

  localparam int POR_C = 40;
  localparam int CLR_C = 12;
  localparam int MW    = 4;

  typedef enum int {PH_HOLD, PH_CLEAR, PH_WAIT, PH_CFG, PH_START, PH_OPER} ph_e;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr, init_line, reset_n, prgm_n, fv, fl, be, keep;
  logic [MW-1:0] mode;
  logic          init_drive, done, hdc, ldc, mem_clr, dout_en, io_act, rst_rel;
  logic [MW-1:0] cfg_mode;
  logic [7:0]    outs;

  int n_chk = 0;
  int n_bad = 0;
  bit once  = 1'b0;

  always #4 clk = ~clk;

  cfg_seq #(
    .MODE_W(MW), .POR_CYCLES(POR_C), .CLR_CYCLES(CLR_C), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr), .init_line_i(init_line),
    .reset_req_ni(reset_n), .prgm_req_ni(prgm_n), .mode_i(mode),
    .frame_valid_i(fv), .frame_last_i(fl), .bit_err_i(be), .keep_mem_i(keep),
    .init_drive_o(init_drive), .done_o(done), .hdc_o(hdc), .ldc_o(ldc),
    .mem_clear_o(mem_clr), .dout_en_o(dout_en), .io_active_o(io_act),
    .int_rst_rel_o(rst_rel), .cfg_mode_o(cfg_mode)
  );

  assign outs = {init_drive, done, hdc, ldc, mem_clr, dout_en, io_act, rst_rel};

  function automatic logic [7:0] exp_outs(ph_e p);
    case (p)
      PH_HOLD:  return 8'hA0;
      PH_CLEAR: return 8'hA8;
      PH_WAIT:  return 8'h20;
      PH_CFG:   return 8'h24;
      PH_START: return 8'h60;
      default:  return 8'h53;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic wait_cfg(output int cyc, output bit saw_clr);
    cyc = 0;
    saw_clr = mem_clr;
    while (!dout_en && cyc < 400) begin
      step(1);
      cyc++;
      if (mem_clr) saw_clr = 1'b1;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int  n;
    bit  saw;
    void'($urandom(32'h5eed_c0de));
    pwr = 0; init_line = 1; reset_n = 1; prgm_n = 1;
    fv = 0; fl = 0; be = 0; keep = 0; mode = '0;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1 reset state", outs, exp_outs(PH_HOLD));
    step(5);
    chk("R12 unpowered hold", outs, exp_outs(PH_HOLD));

    // power-on delay, INIT held low from outside
    init_line = 0; pwr = 1; n = 0;
    do begin step(1); n++; end while (!mem_clr && n < 200);
    chk("R2 por delay", n, POR_C + 1);

    n = 0;
    while (mem_clr && n < 100) begin
      chk("R3 init low while clearing", init_drive, 1);
      n++;
      step(1);
    end
    chk("R3 clear length", n, CLR_C);
    chk("R3 release after clear", outs, exp_outs(PH_WAIT));

    step(10);
    chk("R4 waits for line", outs, exp_outs(PH_WAIT));
    init_line = 1; step(1); init_line = 0;
    step(8);
    chk("R4 single high ignored", outs, exp_outs(PH_WAIT));

    mode = 4'hA; init_line = 1; n = 0;
    do begin step(1); n++; end while (!dout_en && n < 50);
    chk("R4 entry latency", n, 4);
    chk("R6 config outputs", outs, exp_outs(PH_CFG));
    chk("R5 mode latched", cfg_mode, 4'hA);
    mode = 4'h5;
    step(3);
    chk("R5 mode held", cfg_mode, 4'hA);

    fv = 1; step(4);
    fv = 0; be = 1; step(1); be = 0;
    chk("R8 error without strobe ignored", outs, exp_outs(PH_CFG));
    fv = 1; fl = 1; step(1); fv = 0; fl = 0;
    chk("R7 start-up", outs, exp_outs(PH_START));
    step(1);
    chk("R7 operation", outs, exp_outs(PH_OPER));
    once = 1;

    reset_n = 0; init_line = 0;
    step(8);
    chk("R10 reset and init ignored", outs, exp_outs(PH_OPER));
    reset_n = 1; init_line = 1;
    step(3);

    keep = 1; prgm_n = 0;
    step(3);
    chk("R10 program leaves operation", outs, exp_outs(PH_HOLD));
    step(5);
    chk("R9 held by program", outs, exp_outs(PH_HOLD));
    prgm_n = 1;
    wait_cfg(n, saw);
    chk("R11 clear skipped", saw, 0);
    chk("R11 back in config", outs, exp_outs(PH_CFG));

    // completion and abort on the same strobe
    fv = 1; fl = 1; be = 1; step(1); fv = 0; fl = 0; be = 0;
    chk("R8 error beats last frame", outs, exp_outs(PH_HOLD));
    wait_cfg(n, saw);
    chk("R11 skip after abort", saw, 0);

    keep = 0; init_line = 0;
    step(3);
    chk("R9 init low in config", outs, exp_outs(PH_HOLD));
    init_line = 1;
    wait_cfg(n, saw);
    chk("R11 clear without option", saw, 1);

    reset_n = 0;
    step(3);
    chk("R9 reset in config", outs, exp_outs(PH_HOLD));
    step(4);
    chk("R9 held by reset", outs, exp_outs(PH_HOLD));
    reset_n = 1;
    wait_cfg(n, saw);

    keep = 1; pwr = 0;
    step(1);
    chk("R12 power loss", outs, exp_outs(PH_HOLD));
    pwr = 1; n = 0; once = 0;
    do begin step(1); n++; end while (!mem_clr && n < 200);
    chk("R12 full delay again", n, POR_C + 1);
    wait_cfg(n, saw);

    for (int it = 0; it < 40; it++) begin
      int nf, ei;
      bit err, died;
      keep = 1'($urandom_range(0, 1));
      nf   = $urandom_range(1, 8);
      err  = ($urandom_range(0, 3) == 0);
      ei   = $urandom_range(0, nf - 1);
      died = 0;
      for (int f = 0; f < nf; f++) begin
        if ($urandom_range(0, 2) == 0) begin
          fv = 0; be = 1'($urandom_range(0, 1)); fl = 1'($urandom_range(0, 1));
          step(1);
        end
        fv = 1; fl = (f == nf - 1); be = err && (f == ei);
        step(1);
        if (err && f == ei) begin died = 1; break; end
      end
      fv = 0; fl = 0; be = 0;
      if (died) begin
        chk("R8 random abort", outs, exp_outs(PH_HOLD));
      end else begin
        chk("R7 random start-up", outs, exp_outs(PH_START));
        step(1);
        chk("R7 random operation", outs, exp_outs(PH_OPER));
        once = 1;
        prgm_n = 0;
        step(3);
        chk("R10 random program", outs, exp_outs(PH_HOLD));
        prgm_n = 1;
      end
      mode = 4'($urandom);
      wait_cfg(n, saw);
      chk("R11 random clear choice", saw, !(keep && once));
      chk("R5 random mode", cfg_mode, mode);
    end

    summary();
    $finish;
  end

endmodule